// File: doc/BRIEF.md
# Cycle, Time and Retired-Instruction Counter Registers

This block keeps two free-running 64-bit event counters for a processor core. One counts clock cycles and the other counts retired instructions. It maps both, plus a read-only copy of an external 64-bit real-time value, onto the 12-bit control-register address space. The core's register-access stage drives an address with a read strobe, a write strobe or both. It gets back the read data and a hit flag in the same cycle. A write takes effect at the next rising clock edge.

The parameter `XLEN` selects a 32-bit or a 64-bit data path. With a 64-bit data path, each counter is a single register. With a 32-bit data path, each 64-bit counter is split into a low-half address and a high-half address. Writing one half leaves the other half alone. Writable machine-level addresses and read-only user-level aliases both reach the same counters. A write to a read-only alias is flagged as illegal and changes nothing.

Top module: `perf_counter_csr`

## Requirements
- R1: While `rstN` is low, both counters are held at zero, and a read of any counter address returns zero.
- R2: The cycle counter adds one on every rising edge as a full 64-bit value, with carry from bit 31 into bit 32. It does not count on an edge where a write to either of its halves is taken; that edge loads the written value instead.
- R3: The retired-instruction counter adds one on an edge where `retirePulse` is high. A write to either of its halves in that same cycle cancels the increment. With `retirePulse` low and no write, it holds its value.
- R4: Address 0xB00 reads and writes cycle bits XLEN-1:0, and 0xB02 does the same for the retired-instruction counter. Read data is combinational and shows the value before any write in that same cycle.
- R5: With XLEN=32, 0xB80 and 0xB82 read and write bits 63:32 of cycle and retired-instruction. Writing one half leaves the other half unchanged.
- R6: Read-only aliases: 0xC00 gives cycle, 0xC01 gives `timeIn` and 0xC02 gives retired-instruction, each bits XLEN-1:0. With XLEN=32, 0xC80, 0xC81 and 0xC82 give bits 63:32 of the same three values.
- R7: `csrHit` is high only when a strobe is active and the address is one of those in R4 to R6. With XLEN=64, 0xB80, 0xB82 and 0xC80 to 0xC82 give no hit. `csrRdata` is zero unless `csrRead` is high and the address hits.
- R8: A write strobe to a read-only alias (0xC00 to 0xC02, and on XLEN=32 also 0xC80 to 0xC82) raises `csrIllegal` in that cycle. It leaves both counters unchanged apart from their normal counting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| retirePulse | input | 1 | One instruction retires this cycle |
| timeIn | input | 64 | External real-time value |
| csrAddr | input | 12 | Register address |
| csrRead | input | 1 | Read strobe |
| csrWrite | input | 1 | Write strobe |
| csrWdata | input | XLEN | Write data |
| csrRdata | output | XLEN | Read data, valid in the strobe cycle |
| csrHit | output | 1 | Address is mapped for this XLEN |
| csrIllegal | output | 1 | Write aimed at a read-only alias |

## Verification
The hit flag, the illegal flag and the read data depend on the address and the current counter state through logic only, so they are due in the same cycle as the strobe. Writes and increments show up only after the next rising edge. The bench drives every access at the falling edge and compares all three outputs one time unit later, well before the rising edge that commits the access. A bench-side model of both counters advances at each rising edge from the same inputs. Because of this, each read is compared with the value left by all earlier edges and never with the value its own access produces. Directed sequences then read back a written value one edge after the write, to check the carry, the cancelled increment and the untouched-half rules.

// File: rtl/perf_ctr_pkg.sv
package perf_ctr_pkg;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CYC_LO,
    SEL_CYC_HI,
    SEL_RET_LO,
    SEL_RET_HI,
    SEL_TIME_LO,
    SEL_TIME_HI
  } rdSel_e;

  typedef struct packed {
    logic   wrCycLo;
    logic   wrCycHi;
    logic   wrRetLo;
    logic   wrRetHi;
    logic   readEn;
    rdSel_e rdSel;
  } ctrStrobe_t;

  localparam logic [11:0] ADDR_M_CYC_LO = 12'hB00;
  localparam logic [11:0] ADDR_M_RET_LO = 12'hB02;
  localparam logic [11:0] ADDR_M_CYC_HI = 12'hB80;
  localparam logic [11:0] ADDR_M_RET_HI = 12'hB82;
  localparam logic [11:0] ADDR_U_CYC_LO = 12'hC00;
  localparam logic [11:0] ADDR_U_TIM_LO = 12'hC01;
  localparam logic [11:0] ADDR_U_RET_LO = 12'hC02;
  localparam logic [11:0] ADDR_U_CYC_HI = 12'hC80;
  localparam logic [11:0] ADDR_U_TIM_HI = 12'hC81;
  localparam logic [11:0] ADDR_U_RET_HI = 12'hC82;

endpackage

// File: rtl/ctr_decode.sv
module ctr_decode
  import perf_ctr_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [11:0] csrAddr,
  input  logic        csrRead,
  input  logic        csrWrite,
  output ctrStrobe_t  strobe,
  output logic        csrHit,
  output logic        csrIllegal
);

  localparam bit HAS_HI = (XLEN == 32);

  logic   known;
  logic   readOnly;
  rdSel_e sel;
  logic   tgtCycLo, tgtCycHi, tgtRetLo, tgtRetHi;

  always_comb begin
    known    = 1'b0;
    readOnly = 1'b0;
    sel      = SEL_NONE;
    tgtCycLo = 1'b0;
    tgtCycHi = 1'b0;
    tgtRetLo = 1'b0;
    tgtRetHi = 1'b0;
    case (csrAddr)
      ADDR_M_CYC_LO: begin known = 1'b1; sel = SEL_CYC_LO; tgtCycLo = 1'b1; end
      ADDR_M_RET_LO: begin known = 1'b1; sel = SEL_RET_LO; tgtRetLo = 1'b1; end
      ADDR_M_CYC_HI: if (HAS_HI) begin known = 1'b1; sel = SEL_CYC_HI; tgtCycHi = 1'b1; end
      ADDR_M_RET_HI: if (HAS_HI) begin known = 1'b1; sel = SEL_RET_HI; tgtRetHi = 1'b1; end
      ADDR_U_CYC_LO: begin known = 1'b1; readOnly = 1'b1; sel = SEL_CYC_LO;  end
      ADDR_U_TIM_LO: begin known = 1'b1; readOnly = 1'b1; sel = SEL_TIME_LO; end
      ADDR_U_RET_LO: begin known = 1'b1; readOnly = 1'b1; sel = SEL_RET_LO;  end
      ADDR_U_CYC_HI: if (HAS_HI) begin known = 1'b1; readOnly = 1'b1; sel = SEL_CYC_HI;  end
      ADDR_U_TIM_HI: if (HAS_HI) begin known = 1'b1; readOnly = 1'b1; sel = SEL_TIME_HI; end
      ADDR_U_RET_HI: if (HAS_HI) begin known = 1'b1; readOnly = 1'b1; sel = SEL_RET_HI;  end
      default: ;
    endcase
  end

  always_comb begin
    strobe.wrCycLo = csrWrite & tgtCycLo;
    strobe.wrCycHi = csrWrite & tgtCycHi;
    strobe.wrRetLo = csrWrite & tgtRetLo;
    strobe.wrRetHi = csrWrite & tgtRetHi;
    strobe.readEn  = csrRead & known;
    strobe.rdSel   = sel;
    csrHit         = (csrRead | csrWrite) & known;
    csrIllegal     = csrWrite & known & readOnly;
  end

  // R8
  ro_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    csrIllegal |-> !(strobe.wrCycLo || strobe.wrCycHi || strobe.wrRetLo || strobe.wrRetHi));

  // R7
  hit_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(csrRead || csrWrite) |-> (!csrHit && !strobe.readEn && !csrIllegal));

endmodule

// File: rtl/ctr_reg.sv
module ctr_reg #(
  parameter int XLEN  = 32,
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             incEn,
  input  logic             wrLo,
  input  logic             wrHi,
  input  logic [XLEN-1:0]  wdata,
  output logic [CNT_W-1:0] count
);

  localparam int HALF = 32;
  localparam int HI_W = CNT_W - HALF;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (wrLo || wrHi) begin
      if (wrLo) count[XLEN-1:0]       <= wdata;
      if (wrHi) count[CNT_W-1:HALF]   <= wdata[HI_W-1:0];
    end else if (incEn) begin
      count <= count + 1'b1;
    end
  end

  // R2 R3
  inc_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (incEn && !wrLo && !wrHi) |=> count == $past(count) + 1'b1);

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!incEn && !wrLo && !wrHi) |=> $stable(count));

  // R5
  hi_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrHi && !wrLo) |=> count[HALF-1:0] == $past(count[HALF-1:0]));

  generate
    if (XLEN < CNT_W) begin : g_split
      // R5
      lo_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
        (wrLo && !wrHi) |=> count[CNT_W-1:XLEN] == $past(count[CNT_W-1:XLEN]));
    end
  endgenerate

endmodule

// File: rtl/ctr_datapath.sv
module ctr_datapath
  import perf_ctr_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             retirePulse,
  input  logic [CNT_W-1:0] timeIn,
  input  logic [XLEN-1:0]  csrWdata,
  input  ctrStrobe_t       strobe,
  output logic [XLEN-1:0]  csrRdata
);

  localparam int HALF = 32;

  logic [CNT_W-1:0] cycCount;
  logic [CNT_W-1:0] retCount;

  ctr_reg #(.XLEN(XLEN), .CNT_W(CNT_W)) u_cycReg (
    .clk   (clk),
    .rstN  (rstN),
    .incEn (1'b1),
    .wrLo  (strobe.wrCycLo),
    .wrHi  (strobe.wrCycHi),
    .wdata (csrWdata),
    .count (cycCount)
  );

  ctr_reg #(.XLEN(XLEN), .CNT_W(CNT_W)) u_retReg (
    .clk   (clk),
    .rstN  (rstN),
    .incEn (retirePulse),
    .wrLo  (strobe.wrRetLo),
    .wrHi  (strobe.wrRetHi),
    .wdata (csrWdata),
    .count (retCount)
  );

  always_comb begin
    csrRdata = '0;
    if (strobe.readEn) begin
      case (strobe.rdSel)
        SEL_CYC_LO:  csrRdata = cycCount[XLEN-1:0];
        SEL_CYC_HI:  csrRdata = XLEN'(cycCount[CNT_W-1:HALF]);
        SEL_RET_LO:  csrRdata = retCount[XLEN-1:0];
        SEL_RET_HI:  csrRdata = XLEN'(retCount[CNT_W-1:HALF]);
        SEL_TIME_LO: csrRdata = timeIn[XLEN-1:0];
        SEL_TIME_HI: csrRdata = XLEN'(timeIn[CNT_W-1:HALF]);
        default:     csrRdata = '0;
      endcase
    end
  end

  // R7
  rd_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.readEn |-> csrRdata == '0);

endmodule

// File: rtl/perf_counter_csr.sv
module perf_counter_csr
  import perf_ctr_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            retirePulse,
  input  logic [63:0]     timeIn,
  input  logic [11:0]     csrAddr,
  input  logic            csrRead,
  input  logic            csrWrite,
  input  logic [XLEN-1:0] csrWdata,
  output logic [XLEN-1:0] csrRdata,
  output logic            csrHit,
  output logic            csrIllegal
);

  localparam int CNT_W = 64;

  ctrStrobe_t strobe;

  ctr_decode #(.XLEN(XLEN)) u_decode (
    .clk        (clk),
    .rstN       (rstN),
    .csrAddr    (csrAddr),
    .csrRead    (csrRead),
    .csrWrite   (csrWrite),
    .strobe     (strobe),
    .csrHit     (csrHit),
    .csrIllegal (csrIllegal)
  );

  ctr_datapath #(.XLEN(XLEN), .CNT_W(CNT_W)) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .retirePulse (retirePulse),
    .timeIn      (timeIn),
    .csrWdata    (csrWdata),
    .strobe      (strobe),
    .csrRdata    (csrRdata)
  );

endmodule

// File: tb/perf_counter_csr_bench.sv
module perf_counter_csr_bench;

  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        retire = 1'b0;
  logic [63:0] timeIn = '0;
  logic [11:0] addr = '0;
  logic        rd = 1'b0;
  logic        wr = 1'b0;
  logic [63:0] wdata = '0;

  logic [31:0] rdata32;
  logic        hit32, ill32;
  logic [63:0] rdata64;
  logic        hit64, ill64;

  int total = 0;
  int bad = 0;

  logic [63:0] mCyc32, mRet32, mCyc64, mRet64;
  logic wl, wh, rl, rh;

  always #(PERIOD/2) clk = ~clk;

  perf_counter_csr #(.XLEN(32)) u_perf_counter_csr (
    .clk(clk), .rstN(rstN), .retirePulse(retire), .timeIn(timeIn),
    .csrAddr(addr), .csrRead(rd), .csrWrite(wr), .csrWdata(wdata[31:0]),
    .csrRdata(rdata32), .csrHit(hit32), .csrIllegal(ill32));

  perf_counter_csr #(.XLEN(64)) u_perf_counter_csr64 (
    .clk(clk), .rstN(rstN), .retirePulse(retire), .timeIn(timeIn),
    .csrAddr(addr), .csrRead(rd), .csrWrite(wr), .csrWdata(wdata),
    .csrRdata(rdata64), .csrHit(hit64), .csrIllegal(ill64));

  // bench model of both counter pairs, advanced at each rising edge
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCyc32 = '0; mRet32 = '0; mCyc64 = '0; mRet64 = '0;
    end else begin
      wl = wr && addr == 12'hB00; wh = wr && addr == 12'hB80;
      rl = wr && addr == 12'hB02; rh = wr && addr == 12'hB82;
      if (wl || wh) begin
        if (wl) mCyc32[31:0]  = wdata[31:0];
        if (wh) mCyc32[63:32] = wdata[31:0];
      end else mCyc32 = mCyc32 + 1;
      if (rl || rh) begin
        if (rl) mRet32[31:0]  = wdata[31:0];
        if (rh) mRet32[63:32] = wdata[31:0];
      end else if (retire) mRet32 = mRet32 + 1;
      if (wl) mCyc64 = wdata; else mCyc64 = mCyc64 + 1;
      if (rl) mRet64 = wdata; else if (retire) mRet64 = mRet64 + 1;
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic expect_map(input bit is32, input logic [11:0] a,
                            input logic [63:0] cyc, input logic [63:0] ret,
                            output logic hit, output logic ro,
                            output logic [63:0] val, output string tag);
    hit = 1'b1; ro = 1'b0; val = '0; tag = "R7";
    case (a)
      12'hB00: begin val = cyc; tag = "R4"; end
      12'hB02: begin val = ret; tag = "R4"; end
      12'hC00: begin val = cyc;    ro = 1'b1; tag = "R6"; end
      12'hC01: begin val = timeIn; ro = 1'b1; tag = "R6"; end
      12'hC02: begin val = ret;    ro = 1'b1; tag = "R6"; end
      12'hB80: if (is32) begin val = cyc >> 32; tag = "R5"; end else hit = 1'b0;
      12'hB82: if (is32) begin val = ret >> 32; tag = "R5"; end else hit = 1'b0;
      12'hC80: if (is32) begin val = cyc >> 32;    ro = 1'b1; tag = "R6"; end else hit = 1'b0;
      12'hC81: if (is32) begin val = timeIn >> 32; ro = 1'b1; tag = "R6"; end else hit = 1'b0;
      12'hC82: if (is32) begin val = ret >> 32;    ro = 1'b1; tag = "R6"; end else hit = 1'b0;
      default: hit = 1'b0;
    endcase
    if (is32) val = {32'h0, val[31:0]};
  endtask

  // drive one access at the falling edge, compare outputs before the next rising edge
  task automatic step(input logic [11:0] a, input logic r, input logic w,
                      input logic [63:0] wd, input logic ret);
    logic h, ro;
    logic [63:0] v;
    string tag;
    @(negedge clk);
    addr = a; rd = r; wr = w; wdata = wd; retire = ret;
    #1;
    expect_map(1'b1, a, mCyc32, mRet32, h, ro, v, tag);
    check("R7 hit32", {63'h0, hit32}, {63'h0, h & (r | w)});
    check("R8 illegal32", {63'h0, ill32}, {63'h0, h & ro & w});
    check({tag, " rdata32"}, {32'h0, rdata32}, (h & r) ? v : 64'h0);
    expect_map(1'b0, a, mCyc64, mRet64, h, ro, v, tag);
    check("R7 hit64", {63'h0, hit64}, {63'h0, h & (r | w)});
    check("R8 illegal64", {63'h0, ill64}, {63'h0, h & ro & w});
    check({tag, " rdata64"}, rdata64, (h & r) ? v : 64'h0);
  endtask

  initial begin
    #(PERIOD * 200000);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: reset state
    step(12'hB00, 1'b1, 1'b0, '0, 1'b1);
    check("R1 cycle in reset", {32'h0, rdata32}, 64'h0);
    step(12'hC02, 1'b1, 1'b0, '0, 1'b1);
    check("R1 instret in reset", rdata64, 64'h0);
    @(negedge clk);
    rstN = 1'b1;

    // near-exhaustive address sweep with mixed strobes
    for (int i = 0; i < 4096; i++) begin
      timeIn = {32'(i) * 32'd7, 32'hA5A5_0000 + 32'(i)};
      step(12'(i), 1'b1, (i % 3) == 0, {~32'(i), 32'(i) * 32'h9E37_79B9}, i[0] ^ i[2]);
    end

    // R2: carry across halves, writes suppress counting
    step(12'hB80, 1'b0, 1'b1, 64'h1, 1'b0);
    step(12'hB00, 1'b0, 1'b1, 64'hFFFF_FFFE, 1'b0);
    step(12'hB00, 1'b1, 1'b0, '0, 1'b0);
    check("R4 cycle lo after write", {32'h0, rdata32}, 64'hFFFF_FFFE);
    step(12'hB00, 1'b1, 1'b0, '0, 1'b0);
    check("R2 cycle counts", {32'h0, rdata32}, 64'hFFFF_FFFF);
    step(12'hB80, 1'b1, 1'b0, '0, 1'b0);
    check("R2 carry into high half", {32'h0, rdata32}, 64'h2);

    // R3: write cancels retire increment
    step(12'hB82, 1'b0, 1'b1, 64'h55, 1'b1);
    step(12'hB02, 1'b0, 1'b1, 64'd10, 1'b1);
    step(12'hB02, 1'b1, 1'b0, '0, 1'b1);
    check("R3 retire cancelled by write", {32'h0, rdata32}, 64'd10);
    step(12'hB02, 1'b1, 1'b0, '0, 1'b0);
    check("R3 retire counts", {32'h0, rdata32}, 64'd11);
    step(12'hB02, 1'b1, 1'b0, '0, 1'b0);
    check("R3 hold without retire", {32'h0, rdata32}, 64'd11);
    step(12'hB82, 1'b1, 1'b0, '0, 1'b0);
    check("R5 high half kept", {32'h0, rdata32}, 64'h55);

    // R8: write to read-only alias
    step(12'hC02, 1'b0, 1'b1, 64'hDEAD, 1'b0);
    check("R8 illegal flag", {63'h0, ill32}, 64'h1);
    step(12'hB02, 1'b1, 1'b0, '0, 1'b0);
    check("R8 no effect", {32'h0, rdata32}, 64'd11);

    // R6: time alias halves
    timeIn = 64'h1122_3344_5566_7788;
    step(12'hC81, 1'b1, 1'b0, '0, 1'b0);
    check("R6 time high", {32'h0, rdata32}, 64'h1122_3344);
    step(12'hC01, 1'b1, 1'b0, '0, 1'b0);
    check("R6 time low", {32'h0, rdata32}, 64'h5566_7788);
    check("R6 time full", rdata64, 64'h1122_3344_5566_7788);

    // R7: high addresses unmapped on the wide build
    step(12'hB80, 1'b1, 1'b0, '0, 1'b0);
    check("R7 no hit wide", {63'h0, hit64}, 64'h0);

    // R4: full-width write on the wide build
    step(12'hB00, 1'b0, 1'b1, 64'h0123_4567_89AB_CDEF, 1'b0);
    step(12'hB00, 1'b1, 1'b0, '0, 1'b0);
    check("R4 wide write", rdata64, 64'h0123_4567_89AB_CDEF);
    step(12'hC00, 1'b1, 1'b0, '0, 1'b0);
    check("R6 wide cycle alias", rdata64, 64'h0123_4567_89AB_CDF0);

    @(negedge clk);
    rd = 1'b0; wr = 1'b0;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule